// File: doc/BRIEF.md
# DMA Request/Grant Handshake Controller

This block runs the device side of one external DMA channel's handshake. An external peripheral asks for a transfer by pulling an active-low request line low. Once the request is recognised, the block drives an active-low grant strobe. The falling edge of the grant opens the access. The rising edge marks the point where the peripheral's data is captured on a write, or where the block's read data is released. A read strobe or a write strobe, chosen by a direction input at the start of the access, follows the grant cycle for cycle.

The grant stays low for one base cycle plus a programmed number of wait states. If the peripheral still holds its request low when that time is over, the access is stretched one cycle at a time until the request rises. An optional bus idle cycle adds one more grant-high cycle before the next grant can start.

The request line is either registered once, for a peripheral that switches it synchronously with the clock, or passed through a two-stage synchroniser, for a free-running peripheral. The wait count, the idle-cycle enable and the direction are captured only when an access starts.

Top module: `dma_hs_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no request, grant_n, rd_n and wr_n are 1 and done is 0.
- R2: With req_is_sync=1 the grant first reads low after the first clock edge following the edge that sampled req_n low. With req_is_sync=0 this takes two edges. The grant never falls without a recognised request.
- R3: When the request is released early, grant_n stays low for exactly wait_states+1 cycles (wait_states is 3-bit, 0 to 7).
- R4: If req_n is sampled low for H consecutive edges starting with the recognising one, grant_n stays low for max(wait_states+1, H) cycles.
- R5: With xfer_write=1, wr_n equals grant_n and rd_n stays 1. With xfer_write=0, rd_n equals grant_n and wr_n stays 1.
- R6: done is high for exactly one cycle, the first cycle in which grant_n is high again after an access.
- R7: Between the end of one grant and the start of the next, grant_n stays high for at least 1 cycle, or at least 2 cycles when idle_gap_en=1. With a pending request the high time is exactly that minimum.
- R8: Changes to wait_states, idle_gap_en or xfer_write while a grant is low do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | 1 | Active-low transfer request from the peripheral |
| req_is_sync | input | 1 | 1: request is registered once; 0: request goes through the two-stage synchroniser |
| xfer_write | input | 1 | Direction of the next access: 1 write, 0 read |
| wait_states | input | 3 | Extra grant-low cycles for the next access |
| idle_gap_en | input | 1 | Adds one bus idle cycle after each access |
| grant_n | output | 1 | Active-low grant strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle pulse when an access completes |

## Verification
The assertions assume that req_is_sync changes only while no request is pending and both synchroniser stages hold the idle value. They also assume that the request line is a clean level sampled by the clock, so the synchroniser never sees a metastable value. The stimulus drives every input at the falling clock edge. It switches the request mode only after several idle cycles with the request released, and it keeps each request low until the bench has accounted for it. Configuration inputs are changed on purpose while a grant is low, and the bench checks that the running access does not change.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_GRANT = 2'd1,
    HS_GAP   = 2'd2
  } hs_state_t;
endpackage

// File: rtl/dma_hs_rst_sync.sv
module dma_hs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_ni = rs_q[1];
endmodule

// File: rtl/dma_hs_req_sync.sv
module dma_hs_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic req_n,
  input  logic direct,
  output logic req_act
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign stg_d[i] = ~req_n;
      end else begin : g_next
        assign stg_d[i] = stg_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign req_act = direct ? stg_q[0] : stg_q[STAGES-1];
endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
  import dma_hs_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req_act,
  input  logic              xfer_write,
  input  logic [WAIT_W-1:0] wait_states,
  input  logic              idle_gap_en,
  output logic              grant_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              done
);
  localparam int GL_W = WAIT_W + 2;
  localparam logic [GL_W-1:0] GL_MAX = {GL_W{1'b1}};

  hs_state_t         state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              wr_q, wr_d;
  logic              gap_q, gap_d;
  logic              cfg_en;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    cfg_en  = 1'b0;
    wr_d    = xfer_write;
    gap_d   = idle_gap_en;
    done_d  = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (req_act) begin
          state_d = HS_GRANT;
          cnt_d   = wait_states;
          cnt_en  = 1'b1;
          cfg_en  = 1'b1;
        end
      end
      HS_GRANT: begin
        if (cnt_q != '0) begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end else if (!req_act) begin
          done_d  = 1'b1;
          state_d = gap_q ? HS_GAP : HS_IDLE;
        end
      end
      HS_GAP:  state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      gap_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (cfg_en) begin
        wr_q  <= wr_d;
        gap_q <= gap_d;
      end
    end
  end

  assign grant_n = (state_q != HS_GRANT);
  assign wr_n    = !((state_q == HS_GRANT) && wr_q);
  assign rd_n    = !((state_q == HS_GRANT) && !wr_q);
  assign done    = done_q;

  // Checking aids: grant-low cycle count and the wait value of the access
  logic [GL_W-1:0]   gl_q;
  logic [WAIT_W-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      gl_q   <= '0;
      wait_q <= '0;
    end else begin
      if (state_q != HS_GRANT)  gl_q <= '0;
      else if (gl_q != GL_MAX)  gl_q <= gl_q + 1'b1;
      if (cfg_en) wait_q <= wait_states;
    end
  end

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(grant_n) |-> $past(req_act));

  assert_min_low_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(grant_n) |-> ($past(gl_q) >= GL_W'(wait_q)));

  assert_stretch_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!grant_n && req_act) |=> !grant_n);

  assert_strobe_pair_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    ((rd_n && wr_n) == grant_n) && (rd_n || wr_n));

  assert_done_edge_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> $rose(grant_n));

  assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(grant_n) && gap_q) |=> grant_n);

  assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!grant_n && $past(!grant_n)) |-> ($stable(rd_n) && $stable(wr_n)));
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl #(
  parameter int WAIT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              req_is_sync,
  input  logic              xfer_write,
  input  logic [WAIT_W-1:0] wait_states,
  input  logic              idle_gap_en,
  output logic              grant_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              done
);
  logic rst_ni;
  logic req_act;

  dma_hs_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  dma_hs_req_sync #(.STAGES(SYNC_STAGES)) u_req (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .req_n   (req_n),
    .direct  (req_is_sync),
    .req_act (req_act)
  );

  dma_hs_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .req_act     (req_act),
    .xfer_write  (xfer_write),
    .wait_states (wait_states),
    .idle_gap_en (idle_gap_en),
    .grant_n     (grant_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .done        (done)
  );
endmodule

// File: tb/dma_hs_ctrl_test.sv
`timescale 1ns/1ps
module dma_hs_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_n;
  logic       req_is_sync;
  logic       xfer_write;
  logic [2:0] wait_states;
  logic       idle_gap_en;
  logic       grant_n, rd_n, wr_n, done;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dma_hs_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .req_is_sync(req_is_sync),
    .xfer_write(xfer_write), .wait_states(wait_states), .idle_gap_en(idle_gap_en),
    .grant_n(grant_n), .rd_n(rd_n), .wr_n(wr_n), .done(done)
  );

  function automatic int exp_lat(bit sync);
    return sync ? 1 : 2;
  endfunction

  function automatic int exp_low(int w, int h);
    return (h > w + 1) ? h : w + 1;
  endfunction

  function automatic int exp_gap(bit idle);
    return idle ? 2 : 1;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_wait(int n);
    int spurious = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (!grant_n || done) spurious++;
    end
    check(spurious == 0, "R2", "grant or done without request", spurious, 0);
  endtask

  task automatic run_xfer(int w, int h, bit idle, bit wr, bit sync, bit twiddle);
    int L = exp_lat(sync);
    int e = exp_low(w, h);
    int X = L + e;
    int first = -1, lowcnt = 0, doneat = -1, donecnt = 0, bad = 0;
    wait_states = 3'(w); idle_gap_en = idle; xfer_write = wr; req_is_sync = sync;
    req_n = 1'b0;
    for (int k = 0; k <= X + 3; k++) begin
      @(posedge clk); @(negedge clk);
      if (!grant_n) begin
        if (first < 0) first = k;
        lowcnt++;
      end
      if (wr_n != (wr ? grant_n : 1'b1)) bad++;
      if (rd_n != (wr ? 1'b1 : grant_n)) bad++;
      if (done) begin donecnt++; doneat = k; end
      if (k == h - 1) req_n = 1'b1;
      if (twiddle && k == L) begin
        wait_states = ~3'(w); xfer_write = ~wr; idle_gap_en = ~idle;
      end
    end
    check(first == L, "R2", "grant start latency", first, L);
    if (twiddle) check(lowcnt == e, "R8", "low length after config change", lowcnt, e);
    else if (h > w + 1) check(lowcnt == e, "R4", "stretched low length", lowcnt, e);
    else check(lowcnt == e, "R3", "low length", lowcnt, e);
    check(bad == 0, "R5", "strobe mismatches", bad, 0);
    check(donecnt == 1 && doneat == X, "R6", "done position", doneat, X);
    idle_wait(3);
  endtask

  task automatic run_gap(int w, bit idle, bit sync);
    int L = exp_lat(sync);
    int h = w + 2;
    int X = L + h;
    int second = -1;
    wait_states = 3'(w); idle_gap_en = idle; xfer_write = 1'b0; req_is_sync = sync;
    req_n = 1'b0;
    for (int k = 0; k <= X + 4; k++) begin
      @(posedge clk); @(negedge clk);
      if (k >= X && !grant_n && second < 0) second = k;
      if (k == h - 1) req_n = 1'b1;
      if (k == h) req_n = 1'b0;
    end
    req_n = 1'b1;
    check(second - X == exp_gap(idle), "R7", "grant high cycles", second - X, exp_gap(idle));
    for (int i = 0; i < 20; i++) begin @(posedge clk); @(negedge clk); end
    idle_wait(2);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_n = 1'b1; req_is_sync = 1'b1; xfer_write = 1'b0;
    wait_states = 3'd0; idle_gap_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(grant_n && rd_n && wr_n && !done, "R1", "outputs in reset",
            {grant_n, rd_n, wr_n, done}, 4'b1110);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(grant_n && rd_n && wr_n && !done, "R1", "outputs after reset",
          {grant_n, rd_n, wr_n, done}, 4'b1110);
    idle_wait(4);

    run_xfer(0, 1, 0, 0, 1, 0);
    run_xfer(0, 1, 0, 1, 0, 0);
    run_xfer(7, 1, 1, 1, 1, 0);
    run_xfer(7, 2, 0, 0, 0, 0);
    run_xfer(2, 9, 0, 1, 1, 0);
    run_xfer(0, 5, 1, 0, 0, 0);
    run_xfer(3, 1, 0, 1, 1, 1);
    run_xfer(1, 6, 1, 0, 0, 1);
    run_gap(0, 0, 1);
    run_gap(0, 1, 1);
    run_gap(3, 1, 0);
    run_gap(2, 0, 0);

    for (int n = 0; n < 40; n++) begin
      run_xfer(int'($urandom_range(0, 7)), int'($urandom_range(1, 10)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
    end
    for (int n = 0; n < 8; n++) begin
      run_gap(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule